// File: doc/BRIEF.md
# Prioritized Interrupt Vector Acceptor

This block sits beside a processor core and decides which of 256 interrupt vectors the core should take next. It holds three 256-bit maps: one marks requested vectors, one marks vectors whose handlers are running, and one records whether each vector was last requested as level or edge. It also holds a task-priority value and a 9-bit spurious-vector setting, whose bit 8 enables the whole block.

Requesters present a vector and its trigger type. The core answers a raised interrupt line with an acknowledge pulse, reads back the chosen vector, and later closes the handler with an end-of-interrupt pulse. Priority is decided by the upper four bits of a vector, called its class. A higher vector number always wins.

The processor priority output reports the level that currently blocks delivery. It combines the task priority with the class of the highest running handler.

Top module: `vec_accept`

## Requirements
- R1: Among several requested vectors, the highest-numbered one is accepted first; among running handlers, the highest-numbered one counts for priority and for end-of-interrupt.
- R2: `ppr_o` equals the task priority when the task-priority class (bits 7:4) is at least the class of the highest running vector, or no handler runs; otherwise it equals that running class followed by four zero bits. It reflects registered state, so it follows a write from the next cycle onward.
- R3: `irq_o` is high only when spurious bit 8 is set, at least one vector is requested, and either `ppr_o` is zero or the class of the highest requested vector exceeds the class of `ppr_o`.
- R4: When the task priority is nonzero and the highest requested vector is numerically at or below it, an acknowledge returns the low 8 bits of the spurious setting with `ack_level_o` at 0, and the request stays pending.
- R5: A normal acknowledge moves the highest requested vector from requested to running and returns it on `ack_vector_o`, with `ack_level_o` giving its trigger type (1 = level). Both outputs are valid from the cycle after the acknowledge and hold until the next acknowledge.
- R6: An end-of-interrupt clears only the highest running vector; it has no effect when nothing runs.
- R7: A request marks its vector as requested and stores its trigger type (level 1, edge 0), replacing any earlier type for that vector.
- R8: Reset and `init_i` clear all three maps and the task priority, set the spurious setting to 0xFF (block disabled), and clear the acknowledge outputs.
- R9: A spurious-setting write keeps only write-data bits 8:0; bits 31:9 have no effect.
- R10: When a request, an acknowledge and an end-of-interrupt arrive in one cycle, they are applied in that order. Task-priority and spurious writes in that cycle affect only later cycles.
- R11: An acknowledge while nothing is requested, or while bit 8 is clear, returns the spurious vector with `ack_level_o` at 0 and changes no map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Software re-initialise pulse, same effect as reset |
| req_valid_i | input | 1 | Request strobe |
| req_vector_i | input | 8 | Requested vector |
| req_level_i | input | 1 | Trigger type of the request (1 = level) |
| ack_i | input | 1 | Core acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| tpr_we_i | input | 1 | Task-priority write enable |
| tpr_wdata_i | input | 8 | Task-priority write data |
| svr_we_i | input | 1 | Spurious-setting write enable |
| svr_wdata_i | input | 32 | Spurious-setting write data |
| irq_o | output | 1 | Interrupt line to the core |
| ppr_o | output | 8 | Processor priority |
| ack_vector_o | output | 8 | Vector returned by the last acknowledge |
| ack_level_o | output | 1 | Trigger type of the returned vector |

## Verification
Most internal state can only be seen at the ports with some delay. A missing or extra running bit changes `ppr_o`, and possibly `irq_o`, in the very next cycle. A lost or duplicated request bit stays hidden until an acknowledge returns the wrong vector. A wrong trigger bit shows only as a wrong `ack_level_o` when that vector is taken. For this reason the bench compares `irq_o` and `ppr_o` against a model after every cycle. It also drains each vector through acknowledge and end-of-interrupt, so that hidden map errors reach the ports within a few cycles.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

    localparam int unsigned VEC_W   = 8;
    localparam int unsigned NUM_VEC = 1 << VEC_W;
    localparam int unsigned CLS_W   = 4;
    localparam int unsigned SUB_W   = VEC_W - CLS_W;
    localparam int unsigned SVR_W   = VEC_W + 1;
    localparam int unsigned EN_BIT  = VEC_W;
    localparam int unsigned WORD_W  = 32;

    localparam logic [SVR_W-1:0] SVR_INIT = SVR_W'(9'h0FF);

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [CLS_W-1:0]   cls_t;
    typedef logic [NUM_VEC-1:0] map_t;

    typedef struct packed {
        logic spur;
        vec_t vec;
        logic level;
    } ack_res_t;

    function automatic cls_t cls_of(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction

    function automatic map_t bit_of(input vec_t v);
        map_t m;
        m    = '0;
        m[v] = 1'b1;
        return m;
    endfunction

    function automatic vec_t calc_ppr(input vec_t tpr, input logic isr_any,
                                      input vec_t isr_top);
        cls_t ic;
        ic = isr_any ? cls_of(isr_top) : '0;
        if (cls_of(tpr) >= ic)
            return tpr;
        return {ic, {SUB_W{1'b0}}};
    endfunction

endpackage

// File: rtl/vpa_find_top.sv
module vpa_find_top #(
    parameter int unsigned N  = 256,
    parameter int unsigned WB = 32
) (
    input  logic [N-1:0]         vec,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int unsigned NW = N / WB;
    localparam int unsigned IW = $clog2(N);
    localparam int unsigned BW = $clog2(WB);

    logic [NW-1:0]    wany;
    logic [NW*BW-1:0] wflat;

    generate
        for (genvar w = 0; w < NW; w++) begin : g_word
            logic [BW-1:0] li;
            always_comb begin
                li = '0;
                for (int b = 0; b < WB; b++)
                    if (vec[w*WB + b]) li = BW'(b);
            end
            assign wany[w]             = |vec[w*WB +: WB];
            assign wflat[w*BW +: BW]   = li;
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NW; w++) begin
            if (wany[w]) begin
                found = 1'b1;
                idx   = IW'(w * WB) + IW'(wflat[w*BW +: BW]);
            end
        end
    end

endmodule

// File: rtl/vpa_prio_calc.sv
module vpa_prio_calc
    import vpa_pkg::*;
(
    input  map_t irr_q,
    input  map_t isr_q,
    input  vec_t tpr,
    input  logic sw_en,
    output vec_t ppr,
    output logic irq
);
    logic pend_any, run_any;
    vec_t pend_top, run_top;

    vpa_find_top #(.N(NUM_VEC), .WB(WORD_W)) u_pend (
        .vec(irr_q), .found(pend_any), .idx(pend_top));

    vpa_find_top #(.N(NUM_VEC), .WB(WORD_W)) u_run (
        .vec(isr_q), .found(run_any), .idx(run_top));

    always_comb begin
        ppr = calc_ppr(tpr, run_any, run_top);
        irq = sw_en && pend_any &&
              ((ppr == '0) || (cls_of(pend_top) > cls_of(ppr)));
    end

endmodule

// File: rtl/vpa_vec_state.sv
module vpa_vec_state
    import vpa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     req_valid,
    input  vec_t     req_vec,
    input  logic     req_level,
    input  logic     ack,
    input  logic     eoi,
    input  vec_t     tpr,
    input  logic     sw_en,
    output map_t     irr_q,
    output map_t     isr_q,
    output logic     take,
    output ack_res_t res
);
    map_t tmr_q;
    map_t irr_r, tmr_r, irr_a, isr_a, isr_n;
    logic pf, sf;
    vec_t pidx, sidx;

    // stage 1: request
    always_comb begin
        irr_r = irr_q;
        tmr_r = tmr_q;
        if (req_valid) begin
            irr_r = irr_q | bit_of(req_vec);
            tmr_r = req_level ? (tmr_q | bit_of(req_vec))
                              : (tmr_q & ~bit_of(req_vec));
        end
    end

    vpa_find_top #(.N(NUM_VEC), .WB(WORD_W)) u_after_req (
        .vec(irr_r), .found(pf), .idx(pidx));

    // stage 2: acknowledge
    always_comb begin
        take  = ack && sw_en && pf && !((tpr != '0) && (pidx <= tpr));
        irr_a = take ? (irr_r & ~bit_of(pidx)) : irr_r;
        isr_a = take ? (isr_q | bit_of(pidx))  : isr_q;
        res.spur  = !take;
        res.vec   = pidx;
        res.level = tmr_r[pidx];
    end

    vpa_find_top #(.N(NUM_VEC), .WB(WORD_W)) u_after_ack (
        .vec(isr_a), .found(sf), .idx(sidx));

    // stage 3: end of interrupt
    always_comb begin
        isr_n = (eoi && sf) ? (isr_a & ~bit_of(sidx)) : isr_a;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= irr_a;
            isr_q <= isr_n;
            tmr_q <= tmr_r;
        end
    end

    a_r5_ack_moves: assert property (@(posedge clk) disable iff (rst)
        (take && !eoi && !clr) |=> (isr_q[$past(pidx)] && !irr_q[$past(pidx)]));

    a_r6_eoi_single: assert property (@(posedge clk) disable iff (rst)
        (eoi && !take && !clr && (isr_q != '0))
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    a_r7_req_marks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !take && !clr)
        |=> (irr_q[$past(req_vec)] && (tmr_q[$past(req_vec)] == $past(req_level))));

endmodule

// File: rtl/vec_accept.sv
module vec_accept
    import vpa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init_i,
    input  logic        req_valid_i,
    input  logic [7:0]  req_vector_i,
    input  logic        req_level_i,
    input  logic        ack_i,
    input  logic        eoi_i,
    input  logic        tpr_we_i,
    input  logic [7:0]  tpr_wdata_i,
    input  logic        svr_we_i,
    input  logic [31:0] svr_wdata_i,
    output logic        irq_o,
    output logic [7:0]  ppr_o,
    output logic [7:0]  ack_vector_o,
    output logic        ack_level_o
);
    vec_t             tpr_q;
    logic [SVR_W-1:0] svr_q;
    vec_t             ack_vec_q;
    logic             ack_lvl_q;

    map_t     irr_q, isr_q;
    logic     take;
    ack_res_t res;

    vpa_vec_state u_state (
        .clk       (clk),
        .rst       (rst),
        .clr       (init_i),
        .req_valid (req_valid_i),
        .req_vec   (req_vector_i),
        .req_level (req_level_i),
        .ack       (ack_i),
        .eoi       (eoi_i),
        .tpr       (tpr_q),
        .sw_en     (svr_q[EN_BIT]),
        .irr_q     (irr_q),
        .isr_q     (isr_q),
        .take      (take),
        .res       (res)
    );

    vpa_prio_calc u_prio (
        .irr_q (irr_q),
        .isr_q (isr_q),
        .tpr   (tpr_q),
        .sw_en (svr_q[EN_BIT]),
        .ppr   (ppr_o),
        .irq   (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            tpr_q <= '0;
            svr_q <= SVR_INIT;
        end else begin
            if (tpr_we_i) tpr_q <= tpr_wdata_i;
            if (svr_we_i) svr_q <= svr_wdata_i[SVR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            ack_vec_q <= '0;
            ack_lvl_q <= 1'b0;
        end else if (ack_i) begin
            ack_vec_q <= res.spur ? svr_q[VEC_W-1:0] : res.vec;
            ack_lvl_q <= res.spur ? 1'b0 : res.level;
        end
    end

    assign ack_vector_o = ack_vec_q;
    assign ack_level_o  = ack_lvl_q;

    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> svr_q[EN_BIT]);

    a_r2_ppr_floor: assert property (@(posedge clk) disable iff (rst)
        ppr_o >= tpr_q);

    a_r8_init_quiet: assert property (@(posedge clk) disable iff (rst)
        init_i |=> ((ppr_o == '0) && !irq_o && (svr_q == SVR_INIT)));

    a_r4_spurious_return: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !take && !init_i) |=> (ack_vector_o == $past(svr_q[VEC_W-1:0]) && !ack_level_o));

endmodule

// File: tb/tb_vec_accept.sv
module tb_vec_accept;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [7:0]  req_vector_i = '0;
    logic        req_level_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        eoi_i = 1'b0;
    logic        tpr_we_i = 1'b0;
    logic [7:0]  tpr_wdata_i = '0;
    logic        svr_we_i = 1'b0;
    logic [31:0] svr_wdata_i = '0;
    logic        irq_o;
    logic [7:0]  ppr_o;
    logic [7:0]  ack_vector_o;
    logic        ack_level_o;

    int errors = 0;
    int total  = 0;
    bit done   = 0;

    logic [255:0] m_irr, m_isr, m_tmr;
    logic [7:0]   m_tpr;
    logic [8:0]   m_svr;

    always #10 clk = ~clk;

    vec_accept dut (.*);

    function automatic int hi(input logic [255:0] m);
        for (int i = 255; i >= 0; i--) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int exp_ppr();
        int tc, ic, s;
        s  = hi(m_isr);
        ic = (s < 0) ? 0 : (s >> 4);
        tc = int'(m_tpr) >> 4;
        return (tc >= ic) ? int'(m_tpr) : (ic << 4);
    endfunction

    function automatic bit exp_irq();
        int p, pp;
        p  = hi(m_irr);
        pp = exp_ppr();
        return m_svr[8] && (p >= 0) && ((pp == 0) || ((p >> 4) > (pp >> 4)));
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_outs();
        chk(ppr_o == 8'(exp_ppr()), "R2", "ppr", int'(ppr_o), exp_ppr());
        chk(irq_o == exp_irq(), "R3", "irq", int'(irq_o), int'(exp_irq()));
    endtask

    task automatic model_clear();
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_svr = 9'h0FF;
    endtask

    task automatic step(input bit rq, input logic [7:0] rv, input bit rl,
                        input bit ak, input bit eo, input string tag);
        int p, s;
        logic [7:0] ev;
        bit el;
        req_valid_i = rq; req_vector_i = rv; req_level_i = rl;
        ack_i = ak; eoi_i = eo;
        @(posedge clk); #1;
        req_valid_i = 0; ack_i = 0; eoi_i = 0;
        ev = '0; el = 0;
        if (rq) begin m_irr[rv] = 1'b1; m_tmr[rv] = rl; end
        if (ak) begin
            p = hi(m_irr);
            if (!m_svr[8] || p < 0 || (m_tpr != 0 && p <= int'(m_tpr))) begin
                ev = m_svr[7:0]; el = 0;
            end else begin
                ev = 8'(p); el = m_tmr[p]; m_irr[p] = 1'b0; m_isr[p] = 1'b1;
            end
        end
        if (eo) begin
            s = hi(m_isr);
            if (s >= 0) m_isr[s] = 1'b0;
        end
        chk_outs();
        if (ak) begin
            chk(ack_vector_o == ev, tag, "ack vector", int'(ack_vector_o), int'(ev));
            chk(ack_level_o == el, tag, "ack level", int'(ack_level_o), int'(el));
        end
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        tpr_we_i = 1; tpr_wdata_i = v;
        @(posedge clk); #1;
        tpr_we_i = 0;
        m_tpr = v;
        chk_outs();
    endtask

    task automatic wr_svr(input logic [31:0] v);
        svr_we_i = 1; svr_wdata_i = v;
        @(posedge clk); #1;
        svr_we_i = 0;
        m_svr = v[8:0];
        chk_outs();
    endtask

    task automatic do_init();
        init_i = 1;
        @(posedge clk); #1;
        init_i = 0;
        model_clear();
        chk_outs();
        chk(ack_vector_o == 8'h00, "R8", "ack vector after init", int'(ack_vector_o), 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; total++;
            $display("FAIL watchdog expired: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R8: reset state
        chk_outs();
        chk(ack_vector_o == 8'h00, "R8", "ack vector after reset", int'(ack_vector_o), 0);
        // R11: ack with nothing pending
        step(0, 0, 0, 1, 0, "R11");
        // R11: disabled block keeps pending, returns spurious
        step(1, 8'h50, 1, 0, 0, "R7");
        step(0, 0, 0, 1, 0, "R11");
        // R9: upper write bits ignored; bit 8 clear keeps block disabled
        wr_svr(32'hFFFF_FE40);
        step(0, 0, 0, 1, 0, "R9");
        wr_svr(32'hABCD_E1F0);
        step(0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 1, "R6");

        // R5/R7/R6: every vector, alternating trigger type
        for (int v = 0; v < 256; v++) begin
            step(1, 8'(v), v[0], 0, 0, "R7");
            step(0, 0, 0, 1, 0, "R5");
            step(0, 0, 0, 0, 1, "R6");
        end

        // R1: priority among several pending, nesting
        step(1, 8'h31, 0, 0, 0, "R1");
        step(1, 8'h95, 1, 0, 0, "R1");
        step(1, 8'h94, 0, 0, 0, "R1");
        step(1, 8'hE0, 1, 0, 0, "R1");
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, "R1");
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1, "R6");

        // R4: task priority against pending vector
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < 16; c++) begin
                wr_tpr(8'(t * 16 + ((t * 5) % 16)));
                step(1, 8'(c * 16 + ((c + t) % 16)), c[0], 0, 0, "R7");
                step(0, 0, 0, 1, 0, "R4");
                if (hi(m_isr) >= 0) step(0, 0, 0, 0, 1, "R6");
                if (hi(m_irr) >= 0) begin
                    wr_tpr(8'h00);
                    step(0, 0, 0, 1, 0, "R5");
                    step(0, 0, 0, 0, 1, "R6");
                end
            end
        end

        // R2: processor priority across running class and task class
        for (int i = 0; i < 16; i++) begin
            for (int t = 0; t < 16; t++) begin
                wr_tpr(8'h00);
                step(1, 8'(i * 16 + 9), 0, 0, 0, "R7");
                step(0, 0, 0, 1, 0, "R5");
                wr_tpr(8'(t * 16 + 3));
                step(0, 0, 0, 0, 1, "R2");
            end
        end
        wr_tpr(8'h00);

        // R10: same-cycle ordering
        step(0, 0, 0, 0, 0, "R10");
        step(1, 8'h77, 0, 1, 0, "R10");
        step(1, 8'h20, 0, 1, 0, "R10");
        step(1, 8'h90, 1, 1, 1, "R10");
        chk(ppr_o == 8'h70, "R10", "ppr after mixed cycle", int'(ppr_o), 8'h70);
        step(0, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 1, "R6");

        // R7: re-request replaces trigger type
        step(1, 8'h40, 1, 0, 0, "R7");
        step(1, 8'h40, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 0, "R7");
        step(1, 8'h41, 0, 0, 0, "R7");
        step(1, 8'h41, 1, 0, 0, "R7");
        step(0, 0, 0, 1, 0, "R7");

        // R8: init mid-operation
        step(1, 8'hC3, 0, 0, 0, "R8");
        wr_tpr(8'h55);
        do_init();
        step(0, 0, 0, 1, 0, "R8");
        step(1, 8'h10, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule